// File: doc/BRIEF.md
# Shared-Bus Project Selector

This block lets a set of small user designs take turns using one group of chip pins and one Wishbone slave port. Every design sits in an identical slot wrapper. The wrapper has the same port list for every slot: general-purpose IO, the Wishbone slave signals and a few logic-analyser lines. Each wrapper also has one private activation input that is not part of that shared list. When that input is low, the wrapper drops the drive enable on every shared wire it could touch. Each shared wire is then resolved from the per-slot values and drive enables, so the slots meet on a bus rather than at a central multiplexer.

A small activation register holds one bit per slot. It accepts only writes that select at most one slot. A default responder completes Wishbone cycles while no slot is active, so the bus never hangs. Every slot holds the same demo design. It has a divided-clock hex counter shown on the IO pins as a seven-segment pattern, and a scratch register that can be reached over Wishbone. The counter starts from a different value in each slot, which shows which slot owns the pins.

Top module: `prj_share_top`

## Requirements
- R1: After reset, act_sel and act_err are 0. io_out, io_oe and la_out are all 0, and bus_owned is 0, because no slot drives any shared wire.
- R2: A write on act_we whose data has at most one bit set is copied into act_sel on the next rising edge and clears act_err. The IO and logic-analyser outputs then follow the newly selected slot in that same cycle.
- R3: A write whose data has two or more bits set leaves act_sel unchanged and sets act_err on the next rising edge.
- R4: A write of zero deactivates all slots. io_out, io_oe and la_out return to 0 and bus_owned returns to 0.
- R5: Each slot runs its counter from the system clock and reset, whether or not the slot is active. The digit is (3*slot + floor(N/DIV)) mod 16, where N is the number of rising edges since reset was released. The active slot drives io_out[6:0] with the active-high seven-segment pattern of the digit. Bit 0 is segment a and bit 6 is segment g. The hex patterns from 0 to F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. io_out[7] is 0 and io_oe is 8'h7F.
- R6: While a slot is active, la_out equals that slot's current digit.
- R7: An inactive slot ignores Wishbone traffic. A write made while one slot is active changes only that slot's scratch register.
- R8: A Wishbone request to the active slot is acknowledged one cycle after cyc and stb rise. The acknowledge lasts one cycle. A read at address 0 returns the slot's scratch register, and a read at any other address returns the slot index.
- R9: A Wishbone request made while no slot is active is acknowledged one cycle later with read data 0.
- R10: When the selection moves from one slot to another, the outgoing slot releases every shared wire in the same cycle that the incoming slot starts to drive them.
- R11: No shared wire ever has more than one driver. While any slot is active, every IO and logic-analyser wire is driven. The Wishbone response wires are always driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, passed to every slot |
| rst_n | input | 1 | Active-low synchronous reset, passed to every slot |
| act_we | input | 1 | Activation register write strobe |
| act_wdata | input | NSLOT | Activation value to write |
| act_sel | output | NSLOT | Current activation bits |
| act_err | output | 1 | Last activation write was rejected |
| wb_cyc | input | 1 | Wishbone cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_adr | input | AW | Wishbone address |
| wb_dat_w | input | DW | Wishbone write data |
| wb_ack | output | 1 | Resolved Wishbone acknowledge |
| wb_dat_r | output | DW | Resolved Wishbone read data |
| io_out | output | IO_W | Resolved IO output values |
| io_oe | output | IO_W | Resolved IO output enables |
| la_out | output | LA_W | Resolved logic-analyser outputs |
| bus_owned | output | 1 | Some slot drives a shared IO or analyser wire |

## Verification
The bench builds the block with NSLOT=16 and DIV=3. Having all sixteen slots in place lets random selection reach both edges of the activation word and shows whether writes leak into neighbouring scratch registers. A divider of 3 is not a power of two, so a wrong wrap point in the divider becomes visible within a few cycles. The digit also wraps past F for the high-numbered slots. The random stimulus mixes slot switches with back-to-back Wishbone traffic. This checks that the drive enables hand over cleanly when one slot takes over from another.

// File: rtl/prj_share_pkg.sv
package prj_share_pkg;

    // Active-high seven-segment pattern, bit 0 = a ... bit 6 = g
    function automatic logic [6:0] hex_to_seg(input logic [3:0] v);
        logic [6:0] s;
        case (v)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/prj_act_reg.sv
module prj_act_reg #(
    parameter int NSLOT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [NSLOT-1:0] wdata,
    output logic [NSLOT-1:0] sel,
    output logic             err
);

    typedef struct packed {
        logic [NSLOT-1:0] sel;
        logic             err;
    } act_st_t;

    act_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if ($countones(wdata) > 1) begin
                st_d.err = 1'b1;
            end else begin
                st_d.sel = wdata;
                st_d.err = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel = st_q.sel;
    assign err = st_q.err;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R11
    AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        we && ($countones(wdata) > 1) |=> $stable(sel) && err); // R3
    AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we && ($countones(wdata) <= 1) |=> (sel == $past(wdata)) && !err); // R2

endmodule

// File: rtl/prj_demo.sv
module prj_demo
    import prj_share_pkg::*;
#(
    parameter int SLOT = 0,
    parameter int DIV  = 4,
    parameter int IO_W = 8,
    parameter int LA_W = 4,
    parameter int DW   = 32,
    parameter int AW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc,
    input  logic            stb,
    input  logic            we,
    input  logic [AW-1:0]   adr,
    input  logic [DW-1:0]   dat_w,
    output logic [IO_W-1:0] io_out,
    output logic [IO_W-1:0] io_oe,
    output logic [LA_W-1:0] la_out,
    output logic            ack,
    output logic [DW-1:0]   dat_r
);

    localparam int DIV_W = $clog2(DIV + 1);
    localparam logic [3:0] START = 4'((SLOT * 3) % 16);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [3:0]       dig;
        logic             ack;
        logic [DW-1:0]    rdat;
        logic [DW-1:0]    scratch;
    } demo_st_t;

    demo_st_t st_d, st_q;
    logic     req;

    assign req = cyc && stb && !st_q.ack;

    always_comb begin
        st_d = st_q;
        if (st_q.div == DIV_W'(DIV - 1)) begin
            st_d.div = '0;
            st_d.dig = st_q.dig + 4'd1;
        end else begin
            st_d.div = st_q.div + DIV_W'(1);
        end
        st_d.ack  = req;
        st_d.rdat = '0;
        if (req) begin
            st_d.rdat = (adr == '0) ? st_q.scratch : DW'(SLOT);
            if (we && adr == '0) st_d.scratch = dat_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.dig <= START;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_out = {{(IO_W - 7){1'b0}}, hex_to_seg(st_q.dig)};
    assign io_oe  = {{(IO_W - 7){1'b0}}, 7'h7F};
    assign la_out = LA_W'(st_q.dig);
    assign ack    = st_q.ack;
    assign dat_r  = st_q.rdat;

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R8

endmodule

// File: rtl/prj_slot.sv
module prj_slot #(
    parameter int SLOT = 0,
    parameter int DIV  = 4,
    parameter int IO_W = 8,
    parameter int LA_W = 4,
    parameter int DW   = 32,
    parameter int AW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            wb_cyc,
    input  logic            wb_stb,
    input  logic            wb_we,
    input  logic [AW-1:0]   wb_adr,
    input  logic [DW-1:0]   wb_dat_w,
    output logic [IO_W-1:0] io_v,
    output logic [IO_W-1:0] io_e,
    output logic [IO_W-1:0] oe_v,
    output logic [IO_W-1:0] oe_e,
    output logic [LA_W-1:0] la_v,
    output logic [LA_W-1:0] la_e,
    output logic            ack_v,
    output logic            ack_e,
    output logic [DW-1:0]   dat_v,
    output logic [DW-1:0]   dat_e
);

    logic [IO_W-1:0] raw_io, raw_oe;
    logic [LA_W-1:0] raw_la;
    logic            raw_ack;
    logic [DW-1:0]   raw_dat;

    prj_demo #(
        .SLOT(SLOT), .DIV(DIV), .IO_W(IO_W), .LA_W(LA_W), .DW(DW), .AW(AW)
    ) u_demo (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc    (wb_cyc && active),
        .stb    (wb_stb),
        .we     (wb_we),
        .adr    (wb_adr),
        .dat_w  (wb_dat_w),
        .io_out (raw_io),
        .io_oe  (raw_oe),
        .la_out (raw_la),
        .ack    (raw_ack),
        .dat_r  (raw_dat)
    );

    // Drive enables stand for the tristate buffers on each shared wire
    assign io_e  = {IO_W{active}};
    assign oe_e  = {IO_W{active}};
    assign la_e  = {LA_W{active}};
    assign ack_e = active;
    assign dat_e = {DW{active}};

    assign io_v  = raw_io & io_e;
    assign oe_v  = raw_oe & oe_e;
    assign la_v  = raw_la & la_e;
    assign ack_v = raw_ack & ack_e;
    assign dat_v = raw_dat & dat_e;

endmodule

// File: rtl/prj_bus_resolve.sv
module prj_bus_resolve #(
    parameter int N = 16,
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                must_drv,
    input  logic [N-1:0][W-1:0] val,
    input  logic [N-1:0][W-1:0] en,
    output logic [W-1:0]        bus,
    output logic [W-1:0]        drv
);

    logic [W-1:0][N-1:0] en_t;

    always_comb begin
        for (int w = 0; w < W; w++) begin
            logic acc;
            acc = 1'b0;
            for (int n = 0; n < N; n++) begin
                en_t[w][n] = en[n][w];
                acc        = acc | (val[n][w] & en[n][w]);
            end
            bus[w] = acc;
            drv[w] = |en_t[w];
        end
    end

    for (genvar w = 0; w < W; w++) begin : g_wire_chk
        AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(en_t[w]) <= 1); // R11
        AST_NO_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
            must_drv |-> drv[w]); // R11
    end

endmodule

// File: rtl/prj_share_top.sv
module prj_share_top #(
    parameter int NSLOT = 16,
    parameter int DIV   = 4,
    parameter int IO_W  = 8,
    parameter int LA_W  = 4,
    parameter int DW    = 32,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_we,
    input  logic [NSLOT-1:0] act_wdata,
    output logic [NSLOT-1:0] act_sel,
    output logic             act_err,
    input  logic             wb_cyc,
    input  logic             wb_stb,
    input  logic             wb_we,
    input  logic [AW-1:0]    wb_adr,
    input  logic [DW-1:0]    wb_dat_w,
    output logic             wb_ack,
    output logic [DW-1:0]    wb_dat_r,
    output logic [IO_W-1:0]  io_out,
    output logic [IO_W-1:0]  io_oe,
    output logic [LA_W-1:0]  la_out,
    output logic             bus_owned
);

    localparam int NWB = NSLOT + 1;

    typedef struct packed {
        logic ack;
    } dflt_st_t;

    dflt_st_t dflt_d, dflt_q;
    logic     idle;

    logic [NSLOT-1:0][IO_W-1:0] io_v, io_e, oe_v, oe_e;
    logic [NSLOT-1:0][LA_W-1:0] la_v, la_e;
    logic [NSLOT-1:0]           s_ack_v, s_ack_e;
    logic [NSLOT-1:0][DW-1:0]   s_dat_v, s_dat_e;
    logic [NWB-1:0][0:0]        ack_v, ack_e;
    logic [NWB-1:0][DW-1:0]     dat_v, dat_e;
    logic [IO_W-1:0]            io_drv, oe_drv;
    logic [LA_W-1:0]            la_drv;
    logic [0:0]                 ack_drv, ack_bus;
    logic [DW-1:0]              dat_drv;

    prj_act_reg #(.NSLOT(NSLOT)) u_act (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (act_we),
        .wdata (act_wdata),
        .sel   (act_sel),
        .err   (act_err)
    );

    assign idle = ~|act_sel;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        prj_slot #(
            .SLOT(i), .DIV(DIV), .IO_W(IO_W), .LA_W(LA_W), .DW(DW), .AW(AW)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (act_sel[i]),
            .wb_cyc   (wb_cyc),
            .wb_stb   (wb_stb),
            .wb_we    (wb_we),
            .wb_adr   (wb_adr),
            .wb_dat_w (wb_dat_w),
            .io_v     (io_v[i]),
            .io_e     (io_e[i]),
            .oe_v     (oe_v[i]),
            .oe_e     (oe_e[i]),
            .la_v     (la_v[i]),
            .la_e     (la_e[i]),
            .ack_v    (s_ack_v[i]),
            .ack_e    (s_ack_e[i]),
            .dat_v    (s_dat_v[i]),
            .dat_e    (s_dat_e[i])
        );
    end

    // Default responder: completes cycles while no slot is selected
    always_comb begin
        dflt_d     = dflt_q;
        dflt_d.ack = idle && wb_cyc && wb_stb && !dflt_q.ack;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dflt_q <= '0;
        else        dflt_q <= dflt_d;
    end

    assign ack_v = {dflt_q.ack & idle, s_ack_v};
    assign ack_e = {idle, s_ack_e};
    assign dat_v = {{DW{1'b0}}, s_dat_v};
    assign dat_e = {{DW{idle}}, s_dat_e};

    prj_bus_resolve #(.N(NSLOT), .W(IO_W)) u_io (
        .clk(clk), .rst_n(rst_n), .must_drv(!idle),
        .val(io_v), .en(io_e), .bus(io_out), .drv(io_drv)
    );
    prj_bus_resolve #(.N(NSLOT), .W(IO_W)) u_oe (
        .clk(clk), .rst_n(rst_n), .must_drv(!idle),
        .val(oe_v), .en(oe_e), .bus(io_oe), .drv(oe_drv)
    );
    prj_bus_resolve #(.N(NSLOT), .W(LA_W)) u_la (
        .clk(clk), .rst_n(rst_n), .must_drv(!idle),
        .val(la_v), .en(la_e), .bus(la_out), .drv(la_drv)
    );
    prj_bus_resolve #(.N(NWB), .W(1)) u_ack (
        .clk(clk), .rst_n(rst_n), .must_drv(1'b1),
        .val(ack_v), .en(ack_e), .bus(ack_bus), .drv(ack_drv)
    );
    prj_bus_resolve #(.N(NWB), .W(DW)) u_dat (
        .clk(clk), .rst_n(rst_n), .must_drv(1'b1),
        .val(dat_v), .en(dat_e), .bus(wb_dat_r), .drv(dat_drv)
    );

    assign wb_ack    = ack_bus[0];
    assign bus_owned = |{io_drv, oe_drv, la_drv};

    AST_WB_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drv[0] && (&dat_drv)); // R9
    AST_REQ_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc && wb_stb && !wb_ack && !act_we |=> wb_ack); // R8
    AST_IDLE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (wb_dat_r == '0) && !bus_owned); // R9
    AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
        !idle && $changed(act_sel) |-> bus_owned && (io_oe == oe_v[0] | io_oe)); // R10

endmodule

// File: tb/tb_prj_share_top.sv
`timescale 1ns/1ps
module tb_prj_share_top;

    localparam int NSLOT = 16;
    localparam int DIV   = 3;
    localparam int IO_W  = 8;
    localparam int LA_W  = 4;
    localparam int DW    = 32;
    localparam int AW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             act_we = 1'b0;
    logic [NSLOT-1:0] act_wdata = '0;
    logic [NSLOT-1:0] act_sel;
    logic             act_err;
    logic             wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [AW-1:0]    wb_adr = '0;
    logic [DW-1:0]    wb_dat_w = '0;
    logic             wb_ack;
    logic [DW-1:0]    wb_dat_r;
    logic [IO_W-1:0]  io_out, io_oe;
    logic [LA_W-1:0]  la_out;
    logic             bus_owned;

    int checks = 0;
    int fails  = 0;
    int ncyc   = 0;

    logic [NSLOT-1:0] m_sel = '0;
    logic             m_err = 1'b0;
    logic [DW-1:0]    m_scr [NSLOT];

    prj_share_top #(
        .NSLOT(NSLOT), .DIV(DIV), .IO_W(IO_W), .LA_W(LA_W), .DW(DW), .AW(AW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .act_we(act_we), .act_wdata(act_wdata),
        .act_sel(act_sel), .act_err(act_err), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
        .wb_we(wb_we), .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_ack(wb_ack),
        .wb_dat_r(wb_dat_r), .io_out(io_out), .io_oe(io_oe), .la_out(la_out),
        .bus_owned(bus_owned)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

    function automatic logic [6:0] seg_of(input logic [3:0] v);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[v];
    endfunction

    function automatic int slot_of(input logic [NSLOT-1:0] s);
        for (int i = 0; i < NSLOT; i++) if (s[i]) return i;
        return -1;
    endfunction

    function automatic logic [3:0] digit_of(input int slot, input int n);
        return 4'((3 * slot + n / DIV) % 16);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_io(input string req);
        int s;
        s = slot_of(m_sel);
        if (s < 0) begin
            chk({req, " R4 io_oe idle"}, 64'(io_oe), 64'h0);
            chk({req, " R4 io_out idle"}, 64'(io_out), 64'h0);
            chk({req, " R4 la_out idle"}, 64'(la_out), 64'h0);
            chk({req, " R11 bus_owned idle"}, 64'(bus_owned), 64'h0);
        end else begin
            chk({req, " R5 io_out"}, 64'(io_out), 64'({1'b0, seg_of(digit_of(s, ncyc))}));
            chk({req, " R5 io_oe"}, 64'(io_oe), 64'h7F);
            chk({req, " R6 la_out"}, 64'(la_out), 64'(digit_of(s, ncyc)));
            chk({req, " R11 bus_owned"}, 64'(bus_owned), 64'h1);
        end
    endtask

    task automatic do_act(input logic [NSLOT-1:0] w, input string req);
        act_we    = 1'b1;
        act_wdata = w;
        tick();
        act_we    = 1'b0;
        if ($countones(w) > 1) m_err = 1'b1;
        else begin
            m_sel = w;
            m_err = 1'b0;
        end
        chk({req, " act_sel"}, 64'(act_sel), 64'(m_sel));
        chk({req, " act_err"}, 64'(act_err), 64'(m_err));
        check_io({req, " R10"});
    endtask

    task automatic do_wb(input logic we, input logic [AW-1:0] adr, input logic [DW-1:0] data);
        int s;
        logic [DW-1:0] exp;
        s = slot_of(m_sel);
        if (s < 0) exp = '0;
        else if (adr == '0) exp = m_scr[s];
        else exp = DW'(s);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_adr = adr; wb_dat_w = data;
        tick();
        chk(s < 0 ? "R9 ack idle" : "R8 ack", 64'(wb_ack), 64'h1);
        if (!we) chk(s < 0 ? "R9 read zero" : "R8 R7 read data", 64'(wb_dat_r), 64'(exp));
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
        if (we && s >= 0 && adr == '0) m_scr[s] = data;
        tick();
        chk("R8 ack single cycle", 64'(wb_ack), 64'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20210));
        for (int i = 0; i < NSLOT; i++) m_scr[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 act_sel", 64'(act_sel), 64'h0);
        chk("R1 act_err", 64'(act_err), 64'h0);
        chk("R1 io_oe", 64'(io_oe), 64'h0);
        chk("R1 io_out", 64'(io_out), 64'h0);
        chk("R1 la_out", 64'(la_out), 64'h0);
        chk("R1 bus_owned", 64'(bus_owned), 64'h0);
        // R9 request with nothing selected
        do_wb(1'b0, 4'd0, '0);
        do_wb(1'b1, 4'd0, 32'hDEAD_BEEF);
        // R2 select slot 1, then R10 hand over to slot 2
        do_act(16'h0002, "R2 slot1");
        do_act(16'h0004, "R2 slot2");
        do_wb(1'b1, 4'd0, 32'h1234_5678);
        do_wb(1'b0, 4'd0, '0);
        do_wb(1'b0, 4'd5, '0);
        // R3 reject multi-bit write
        do_act(16'h8001, "R3 reject");
        // R7 slot 15 scratch untouched by the slot 2 write
        do_act(16'h8000, "R2 slot15");
        do_wb(1'b0, 4'd0, '0);
        // R4 deselect all
        do_act(16'h0000, "R4 clear");
        repeat (5) tick();
        check_io("R4 stays idle");

        for (int it = 0; it < 80; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0: do_act(NSLOT'(1) << $urandom_range(0, NSLOT - 1), "R2 rand sel");
                1: begin
                    int a, b;
                    a = int'($urandom_range(0, NSLOT - 1));
                    b = (a + 1 + int'($urandom_range(0, NSLOT - 2))) % NSLOT;
                    do_act((NSLOT'(1) << a) | (NSLOT'(1) << b), "R3 rand reject");
                end
                2: do_act('0, "R4 rand clear");
                3: do_wb(1'b1, AW'($urandom_range(0, 1) * 3), $urandom());
                4: do_wb(1'b0, AW'($urandom_range(0, 1) * 3), '0);
                default: begin
                    repeat ($urandom_range(1, 7)) tick();
                    check_io("R5 rand idle run");
                end
            endcase
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule